// File: doc/BRIEF.md
# Write-Once Configuration Register Bank

This block is a small bank of 16-bit configuration registers on a simple single-cycle peripheral bus. Three of the registers are write-once: outside debug, the first supervisor write that touches a register sets its contents and locks it, and every later write to it is dropped without an error. While the debug input is high, writes always land, and a register written in debug is left unlocked. The next normal write is then accepted and locks it again. A fourth register is a read-only device identifier.

One word of the map is a reserved test-unlock location. It always reads as zero. A nonzero write to it raises a test-enable output. A write of zero clears that output and locks it out until the next reset. Only supervisor accesses are honoured. A user access, or any access to an address with no register behind it, changes nothing and ends in a transfer error. Each request is answered on the following cycle with exactly one of acknowledge or error. Read data is returned in that same cycle and reflects the register contents at the time of the request.

Top module: `cfg_once_bank`

## Requirements
- R1: A request sampled on a clock edge is answered in the next cycle with exactly one of `ack_o` or `err_o` high. With no request, both are low in the next cycle.
- R2: A supervisor read at word offset 0x4 returns `{sys_cfg, pwr_cfg}`, and one at offset 0x8 returns `{boot_cfg, DEVICE_ID}`, with the first register in bits 31:16. `rdata_o` is zero for writes and for errors. Address bits 1:0 are ignored.
- R3: After reset, the three writable registers hold their reset parameters, every register is unlocked, `test_en_o` is low and the test lockout is clear.
- R4: Outside debug, the first supervisor write to a writable register that has a nonzero strobe in that register's half takes effect and locks the register. Later non-debug writes to it are acknowledged and ignored.
- R5: Strobe `be_i[3]` covers bits 31:24, `be_i[2]` bits 23:16, `be_i[1]` bits 15:8 and `be_i[0]` bits 7:0. Bytes whose strobe is low are unchanged. A partial write still locks the whole 16-bit register, and a write with no strobe in a register's half leaves that register untouched.
- R6: While `debug_i` is high, supervisor writes to the writable registers always take effect, whatever their lock state.
- R7: A debug write to a register leaves it unlocked. The next non-debug write to it is accepted and locks it.
- R8: A user-mode access (`super_i` low) at any address returns `err_o` and changes no register and no test state.
- R9: A supervisor access at word offset 0x0 or at 0x10 and above returns `err_o` and changes nothing.
- R10: The device-identifier half (offset 0x8, bits 15:0) is read-only. Supervisor writes to it are acknowledged and have no effect.
- R11: The reserved word at offset 0xC always reads as zero. Only the bytes whose strobes are high count as the written value. A write of a nonzero value sets `test_en_o` unless the lockout is set. A write of zero clears `test_en_o` and sets the lockout, which only reset clears. A write with no strobes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| addr_i | input | ADDR_W | Byte address within the bank |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 4 | Byte strobes for a write |
| wdata_i | input | 32 | Write data |
| super_i | input | 1 | 1 = supervisor access, 0 = user access |
| debug_i | input | 1 | Debug mode; bypasses the write-once locks |
| rdata_o | output | 32 | Read data, valid with `ack_o` |
| ack_o | output | 1 | Access completed normally |
| err_o | output | 1 | Transfer error |
| sys_cfg_o | output | 16 | Current system configuration register |
| pwr_cfg_o | output | 16 | Current power control register |
| boot_cfg_o | output | 16 | Current boot configuration register |
| test_en_o | output | 1 | Test features enabled |

## Verification
The assertions assume each request is a single cycle, is seen on one edge, and has its address, strobes, mode and debug inputs steady across that edge. They also assume the debug input does not change inside an access. The bench drives every input on the falling edge and holds it through exactly one rising edge, then drops the request before sampling. It therefore never produces back-to-back overlapping requests or mid-access mode changes. Sweeps cover every word offset in both privilege modes and every strobe pattern, with debug on and off.

// File: rtl/cfg_once_pkg.sv
package cfg_once_pkg;
  localparam int BUS_W   = 32;
  localparam int HALF_W  = 16;
  localparam int BE_W    = BUS_W / 8;
  localparam int HBE_W   = BE_W / 2;
  localparam int NUM_WO  = 3;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_CFG   = 2'd1,
    SEL_BOOT  = 2'd2,
    SEL_RSVD  = 2'd3
  } sel_e;
endpackage

// File: rtl/cfg_once_decode.sv
module cfg_once_decode
  import cfg_once_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              super_i,
  output sel_e              sel_o,
  output logic              ok_o
);
  localparam int WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] W_CFG  = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_BOOT = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_RSVD = WORD_W'(3);

  logic [WORD_W-1:0] word;
  assign word = addr_i[ADDR_W-1:2];

  always_comb begin
    unique case (word)
      W_CFG:   sel_o = SEL_CFG;
      W_BOOT:  sel_o = SEL_BOOT;
      W_RSVD:  sel_o = SEL_RSVD;
      default: sel_o = SEL_NONE;
    endcase
  end

  // only supervisor hits on a mapped word are honoured
  assign ok_o = req_i & super_i & (sel_o != SEL_NONE);
endmodule

// File: rtl/cfg_once_field.sv
module cfg_once_field
  import cfg_once_pkg::*;
#(
  parameter logic [HALF_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              debug_i,
  input  logic [HBE_W-1:0]  be_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] q_o,
  output logic              locked_o
);
  logic hit, take;
  assign hit  = wr_i & (|be_i);
  assign take = hit & (debug_i | ~locked_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o      <= RST_VAL;
      locked_o <= 1'b0;
    end else begin
      if (take) begin
        for (int b = 0; b < HBE_W; b++)
          if (be_i[b]) q_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
      end
      // debug write reopens the register, normal write closes it
      if (hit) locked_o <= ~debug_i;
    end
  end
endmodule

// File: rtl/cfg_once_test_lock.sv
module cfg_once_test_lock (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic zero_i,
  output logic test_en_o,
  output logic lockout_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_en_o <= 1'b0;
      lockout_o <= 1'b0;
    end else if (wr_i) begin
      if (zero_i) begin
        test_en_o <= 1'b0;
        lockout_o <= 1'b1;
      end else if (!lockout_o) begin
        test_en_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_once_bank.sv
module cfg_once_bank
  import cfg_once_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter logic [HALF_W-1:0] SYS_CFG_RST  = 16'h0000,
  parameter logic [HALF_W-1:0] PWR_CFG_RST  = 16'h0000,
  parameter logic [HALF_W-1:0] BOOT_CFG_RST = 16'h0000,
  parameter logic [HALF_W-1:0] DEVICE_ID    = 16'h0001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              super_i,
  input  logic              debug_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [HALF_W-1:0] sys_cfg_o,
  output logic [HALF_W-1:0] pwr_cfg_o,
  output logic [HALF_W-1:0] boot_cfg_o,
  output logic              test_en_o
);
  localparam logic [NUM_WO-1:0][HALF_W-1:0] RST_VALS =
    {BOOT_CFG_RST, PWR_CFG_RST, SYS_CFG_RST};

  sel_e sel;
  logic ok, wr;
  logic [NUM_WO-1:0][HALF_W-1:0] fld_q;
  logic [NUM_WO-1:0]             fld_lock;
  logic                          lockout;
  logic [BUS_W-1:0]              wmask, rd_mux;

  cfg_once_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i   (req_i),
    .addr_i  (addr_i),
    .super_i (super_i),
    .sel_o   (sel),
    .ok_o    (ok)
  );

  assign wr = ok & we_i;

  // field k: 0 = cfg word hi, 1 = cfg word lo, 2 = boot word hi
  for (genvar k = 0; k < NUM_WO; k++) begin : g_fld
    localparam sel_e FSEL = (k < 2) ? SEL_CFG : SEL_BOOT;
    localparam bit   HI   = (k != 1);
    logic [HBE_W-1:0]  be_h;
    logic [HALF_W-1:0] wd_h;
    assign be_h = HI ? be_i[BE_W-1:HBE_W] : be_i[HBE_W-1:0];
    assign wd_h = HI ? wdata_i[BUS_W-1:HALF_W] : wdata_i[HALF_W-1:0];

    cfg_once_field #(.RST_VAL(RST_VALS[k])) u_fld (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr && (sel == FSEL)),
      .debug_i  (debug_i),
      .be_i     (be_h),
      .wdata_i  (wd_h),
      .q_o      (fld_q[k]),
      .locked_o (fld_lock[k])
    );
  end

  for (genvar b = 0; b < BE_W; b++) begin : g_mask
    assign wmask[b*8 +: 8] = {8{be_i[b]}};
  end

  cfg_once_test_lock u_tst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr && (sel == SEL_RSVD) && (|be_i)),
    .zero_i    ((wdata_i & wmask) == '0),
    .test_en_o (test_en_o),
    .lockout_o (lockout)
  );

  always_comb begin
    unique case (sel)
      SEL_CFG:  rd_mux = {fld_q[0], fld_q[1]};
      SEL_BOOT: rd_mux = {fld_q[2], DEVICE_ID};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= ok;
      err_o   <= req_i & ~ok;
      rdata_o <= (ok & ~we_i) ? rd_mux : '0;
    end
  end

  assign sys_cfg_o  = fld_q[0];
  assign pwr_cfg_o  = fld_q[1];
  assign boot_cfg_o = fld_q[2];
endmodule

// File: rtl/cfg_once_bank_chk.sv
module cfg_once_bank_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              super_i,
  input logic              debug_i,
  input logic [3:0]        be_i,
  input logic [31:0]       rdata_o,
  input logic              ack_o,
  input logic              err_o,
  input logic [15:0]       sys_cfg_o,
  input logic [15:0]       pwr_cfg_o,
  input logic [15:0]       boot_cfg_o,
  input logic              test_en_o,
  input logic [2:0]        locked_i,
  input logic              lockout_i
);
  logic [ADDR_W-3:0] word;
  logic              unmapped;
  assign word     = addr_i[ADDR_W-1:2];
  assign unmapped = (word == '0) || (word > (ADDR_W-2)'(3));

  // R1
  resp_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (ack_o ^ err_o));
  // R1
  resp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !(ack_o || err_o));
  // R2
  err_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rdata_o == '0);
  // R8
  user_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !super_i) |=> err_o && $stable(sys_cfg_o) && $stable(pwr_cfg_o)
                            && $stable(boot_cfg_o) && $stable(test_en_o));
  // R9
  unmapped_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && super_i && unmapped) |=> err_o && $stable(sys_cfg_o)
        && $stable(pwr_cfg_o) && $stable(boot_cfg_o) && $stable(test_en_o));
  // R4
  sys_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && super_i && we_i && !debug_i && word == (ADDR_W-2)'(1) && locked_i[0])
      |=> $stable(sys_cfg_o));
  // R4
  boot_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && super_i && we_i && !debug_i && word == (ADDR_W-2)'(2) && locked_i[2])
      |=> $stable(boot_cfg_o));
  // R7
  dbg_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && super_i && we_i && debug_i && word == (ADDR_W-2)'(1) && (|be_i[3:2]))
      |=> !locked_i[0]);
  // R11
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && super_i && !we_i && word == (ADDR_W-2)'(3)) |=> rdata_o == '0);
  // R11
  lockout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> lockout_i && !$rose(test_en_o));
endmodule

bind cfg_once_bank cfg_once_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .super_i    (super_i),
  .debug_i    (debug_i),
  .be_i       (be_i),
  .rdata_o    (rdata_o),
  .ack_o      (ack_o),
  .err_o      (err_o),
  .sys_cfg_o  (sys_cfg_o),
  .pwr_cfg_o  (pwr_cfg_o),
  .boot_cfg_o (boot_cfg_o),
  .test_en_o  (test_en_o),
  .locked_i   (fld_lock),
  .lockout_i  (lockout)
);

// File: tb/cfg_once_bank_test.sv
`timescale 1ns/1ps
module cfg_once_bank_test;
  localparam int          AW     = 8;
  localparam logic [15:0] SYS_R  = 16'h0a05;
  localparam logic [15:0] PWR_R  = 16'h0000;
  localparam logic [15:0] BOOT_R = 16'h00c3;
  localparam logic [15:0] DEV_ID = 16'h2b41;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, super_i = 1'b0, debug_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [3:0]    be_i = '0;
  logic [31:0]   wdata_i = '0;
  logic [31:0]   rdata_o;
  logic          ack_o, err_o, test_en_o;
  logic [15:0]   sys_cfg_o, pwr_cfg_o, boot_cfg_o;

  always #2.5 clk_i = ~clk_i;

  cfg_once_bank #(
    .ADDR_W(AW), .SYS_CFG_RST(SYS_R), .PWR_CFG_RST(PWR_R),
    .BOOT_CFG_RST(BOOT_R), .DEVICE_ID(DEV_ID)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .we_i(we_i), .be_i(be_i), .wdata_i(wdata_i), .super_i(super_i),
    .debug_i(debug_i), .rdata_o(rdata_o), .ack_o(ack_o), .err_o(err_o),
    .sys_cfg_o(sys_cfg_o), .pwr_cfg_o(pwr_cfg_o), .boot_cfg_o(boot_cfg_o),
    .test_en_o(test_en_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_sys, m_pwr, m_boot;
  logic [2:0]  m_lk;
  logic        m_ten, m_lo;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mdl_fld(inout logic [15:0] v, inout logic lk, input logic [1:0] b,
                         input logic [15:0] d, input logic dbg);
    if (|b) begin
      if (dbg || !lk) begin
        if (b[1]) v[15:8] = d[15:8];
        if (b[0]) v[7:0]  = d[7:0];
      end
      lk = !dbg;
    end
  endtask

  task automatic check_outs(input string tag);
    chk(sys_cfg_o == m_sys,   {tag, " sys_cfg"},  {16'h0, sys_cfg_o},  {16'h0, m_sys});
    chk(pwr_cfg_o == m_pwr,   {tag, " pwr_cfg"},  {16'h0, pwr_cfg_o},  {16'h0, m_pwr});
    chk(boot_cfg_o == m_boot, {tag, " boot_cfg"}, {16'h0, boot_cfg_o}, {16'h0, m_boot});
    chk(test_en_o == m_ten,   {tag, " test_en"},  {31'h0, test_en_o},  {31'h0, m_ten});
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    req_i = 1'b0;
    m_sys = SYS_R; m_pwr = PWR_R; m_boot = BOOT_R;
    m_lk = '0; m_ten = 1'b0; m_lo = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 reset state
    chk(!ack_o && !err_o, "R3 no response after reset", {30'h0, ack_o, err_o}, 32'h0);
    check_outs("R3");
  endtask

  task automatic bus(input logic sup, input logic dbg, input logic wr,
                     input logic [AW-1:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input string tag);
    logic [5:0]  word;
    logic        legal;
    logic [31:0] exp_rd, mask;
    @(negedge clk_i);
    req_i = 1'b1; super_i = sup; debug_i = dbg; we_i = wr;
    addr_i = a; be_i = be; wdata_i = wd;
    word   = a[7:2];
    legal  = sup && (word >= 6'd1) && (word <= 6'd3);
    exp_rd = 32'h0;
    if (legal && !wr) begin
      if (word == 6'd1) exp_rd = {m_sys, m_pwr};
      else if (word == 6'd2) exp_rd = {m_boot, DEV_ID};
    end
    if (legal && wr) begin
      if (word == 6'd1) begin
        mdl_fld(m_sys, m_lk[0], be[3:2], wd[31:16], dbg);
        mdl_fld(m_pwr, m_lk[1], be[1:0], wd[15:0], dbg);
      end else if (word == 6'd2) begin
        mdl_fld(m_boot, m_lk[2], be[3:2], wd[31:16], dbg);
      end else if (word == 6'd3 && |be) begin
        mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        if ((wd & mask) == 32'h0) begin
          m_lo = 1'b1; m_ten = 1'b0;
        end else if (!m_lo) begin
          m_ten = 1'b1;
        end
      end
    end
    @(negedge clk_i);
    chk(ack_o == legal && err_o == !legal, {tag, " R1 ack/err"},
        {30'h0, ack_o, err_o}, {30'h0, legal, !legal});
    chk(rdata_o == exp_rd, {tag, " R2 rdata"}, rdata_o, exp_rd);
    check_outs(tag);
    req_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1 idle cycle: nothing asserted without a request
    @(negedge clk_i);
    chk(!ack_o && !err_o, "R1 idle", {30'h0, ack_o, err_o}, 32'h0);

    // R8 user accesses at every offset, reads and nonzero writes
    for (int w = 0; w < 64; w++) begin
      bus(1'b0, 1'b0, 1'b0, AW'(w * 4), 4'hf, 32'h0, "R8 user read");
      bus(1'b0, w[0], 1'b1, AW'(w * 4), 4'hf, 32'h5a5a_a5a5, "R8 user write");
    end

    // R9 and R2 supervisor sweep; low address bits ignored
    for (int w = 0; w < 64; w++) begin
      bus(1'b1, 1'b0, 1'b0, AW'(w * 4 + (w % 4)), 4'hf, 32'h0, "R9 R2 sup read");
      if (w == 0 || w >= 4)
        bus(1'b1, 1'b0, 1'b1, AW'(w * 4), 4'hf, 32'hffff_ffff, "R9 sup write unmapped");
    end

    // R11 test unlock, read zero, lockout
    bus(1'b1, 1'b0, 1'b1, 8'h0c, 4'h0, 32'hffff_ffff, "R11 no strobe");
    bus(1'b1, 1'b0, 1'b1, 8'h0c, 4'h2, 32'h0000_0100, "R11 unlock");
    bus(1'b1, 1'b0, 1'b0, 8'h0c, 4'hf, 32'h0, "R11 read zero");
    bus(1'b1, 1'b0, 1'b1, 8'h0c, 4'h1, 32'hffff_ff00, "R11 masked zero locks");
    bus(1'b1, 1'b1, 1'b1, 8'h0c, 4'hf, 32'h0000_0001, "R11 locked out");
    bus(1'b1, 1'b0, 1'b1, 8'h0c, 4'hf, 32'h8000_0000, "R11 still locked");

    // R5 partial write locks whole register, R4 later writes dropped
    bus(1'b1, 1'b0, 1'b1, 8'h04, 4'h8, 32'h7700_0000, "R5 partial sys");
    bus(1'b1, 1'b0, 1'b1, 8'h04, 4'hc, 32'h1122_0000, "R4 sys locked");
    bus(1'b1, 1'b0, 1'b1, 8'h04, 4'h3, 32'h0000_3344, "R4 pwr first");
    bus(1'b1, 1'b0, 1'b1, 8'h04, 4'hf, 32'hdead_beef, "R4 both locked");
    bus(1'b1, 1'b0, 1'b0, 8'h04, 4'hf, 32'h0, "R2 read cfg");

    // R6 debug overrides lock, R7 reopens register
    bus(1'b1, 1'b1, 1'b1, 8'h04, 4'hf, 32'h1234_5678, "R6 debug write");
    bus(1'b1, 1'b1, 1'b1, 8'h04, 4'h4, 32'h00ab_0000, "R6 debug again");
    bus(1'b1, 1'b0, 1'b1, 8'h04, 4'hf, 32'h9999_8888, "R7 accepted after debug");
    bus(1'b1, 1'b0, 1'b1, 8'h04, 4'hf, 32'h0101_0202, "R7 relocked");

    // R10 device id read-only; boot via debug first
    bus(1'b1, 1'b0, 1'b1, 8'h08, 4'h3, 32'h0000_ffff, "R10 id write");
    bus(1'b1, 1'b1, 1'b1, 8'h08, 4'hf, 32'h4455_6677, "R6 boot debug");
    bus(1'b1, 1'b0, 1'b1, 8'h08, 4'hf, 32'h6600_0000, "R7 boot accepted");
    bus(1'b1, 1'b0, 1'b1, 8'h08, 4'hf, 32'h7788_0000, "R4 boot locked");
    bus(1'b1, 1'b0, 1'b0, 8'h09, 4'hf, 32'h0, "R10 R2 read boot");

    // R3 reset clears locks and lockout
    do_reset();
    bus(1'b1, 1'b0, 1'b1, 8'h0c, 4'hf, 32'h0000_0010, "R3 R11 unlock after reset");
    bus(1'b1, 1'b0, 1'b1, 8'h04, 4'hf, 32'hcafe_f00d, "R3 R4 unlocked after reset");

    // R5 R6 R7 sweep: every strobe pattern, debug on and off
    do_reset();
    for (int i = 0; i < 128; i++) begin
      bus(1'b1, i[4], 1'b1, (i[5] ? 8'h08 : 8'h04), i[3:0],
          {i[7:0], ~i[7:0], i[7:0] ^ 8'h3c, 8'(i * 7)}, "R5 R6 R7 sweep");
      if (i[6]) bus(1'b1, 1'b0, 1'b0, (i[5] ? 8'h08 : 8'h04), 4'hf, 32'h0, "R2 sweep read");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule